// File: doc/BRIEF.md
# Serial ADC Control Sequencer

This block is the device-side control logic of a serially commanded, multi-channel converter. A host drives an active-low chip select, a serial clock and a serial data line. The block works in a faster system clock. It passes chip select and the serial clock through synchronizers and then detects their edges. On the early rising serial-clock edges it collects an 8-bit command. The command carries a channel address, a transfer-length code, a bit-order flag and a number-format flag. The block counts falling edges to track the I/O cycle. It opens the sample window, and when the cycle ends it starts a conversion and pulls the end-of-conversion flag low.

The analog converter is not part of this block. Its completion is signalled back on `convDone`, and the flag then returns high. One address value puts the block into a power-down state instead of starting a conversion. A chip-select toggle restarts an I/O cycle part way through, or abandons a running conversion. The order and format flags are latched onto parallel outputs so that an output formatter can read them.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `eocFlag` and `powerDown` are 1, `sampleEn` and `convStart` are 0, and `chanAddr`, `xferLen`, `lsbFirst` and `bipolar` are all 0.
- R2: Command bits arrive MSB first, one per rising serial-clock edge, on the first eight rising edges only. Bits 7..4 appear on `chanAddr` once the fourth bit is in. Bits 3..2 appear on `xferLen` once the sixth bit is in. Bit 1 goes to `lsbFirst` and bit 0 goes to `bipolar` once the eighth bit is in. The data line is ignored on any later rising edge.
- R3: The length code selects the number of falling edges in the I/O cycle: 01 gives 8, 11 gives 16, and 00 or 10 gives 12. The code applies to the same cycle that carries it.
- R4: For any address other than 1110, `sampleEn` rises on the fourth falling edge and falls on the last falling edge. It is never high while a conversion runs.
- R5: The last falling edge, and no earlier edge, produces a single-cycle `convStart` pulse with the new address on `chanAddr`, and it drives `eocFlag` low.
- R6: `eocFlag` returns high when `convDone` arrives during a conversion. At any other time `convDone` has no effect.
- R7: Address 1110 raises `powerDown` on the fourth falling edge, with no sampling and no conversion. `eocFlag` stays high. `powerDown` clears only when a cycle with any other address reaches its last falling edge.
- R8: While chip select is high, serial-clock and data activity is ignored. The latched command fields do not change, and no sampling or conversion happens.
- R9: A falling edge of chip select restarts the I/O cycle with its edge counts at zero. If a conversion is running, it is abandoned and `eocFlag` goes high.
- R10: Serial-clock edges that arrive during a conversion are ignored. They do not count toward the next I/O cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select (asynchronous) |
| sclk | input | 1 | Serial I/O clock (asynchronous) |
| sdi | input | 1 | Serial command data |
| convDone | input | 1 | Conversion finished, result latched |
| chanAddr | output | 4 | Latched channel / test / power-down address |
| xferLen | output | 2 | Latched transfer-length code |
| lsbFirst | output | 1 | Latched bit-order flag |
| bipolar | output | 1 | Latched number-format flag |
| sampleEn | output | 1 | Sample window open |
| convStart | output | 1 | One-cycle conversion start pulse |
| eocFlag | output | 1 | End of conversion, high when idle |
| powerDown | output | 1 | Power-down state |

## Verification
The bench builds the block with its default two-stage synchronizers. The serial clock runs at one sixteenth of the system clock, so each serial half-period gives the synchronized edges eight system cycles to settle before sampling. With this ratio the bench can run all three cycle lengths and a power-down cycle followed by wake-up. It can also place a chip-select toggle in the middle of a transfer and during a conversion. A scoreboard of expected conversion addresses catches any start pulse that comes early, twice, or with a stale address.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CMD_BITS   = 8;
  localparam int ADDR_W     = 4;
  localparam int LEN_W      = 2;
  localparam int CNT_W      = 5;
  localparam int RISE_W     = 4;
  localparam int SAMPLE_IDX = 3;
  localparam logic [ADDR_W-1:0] PD_CODE = 4'hE;

  typedef struct packed {
    logic clr;
    logic rise;
    logic fall;
  } ioStrb_t;

  typedef enum logic {ST_IO, ST_CONV} seqState_t;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] lvlDly
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain  <= {STAGES{RST_VAL}};
      lvlDly <= RST_VAL;
    end else begin
      chain  <= {chain[STAGES-2:0], asyncIn};
      lvlDly <= chain[STAGES-1];
    end
  end

  assign lvl = chain[STAGES-1];
endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ioStrb_t           strb,
  input  logic              sdi,
  output logic [ADDR_W-1:0] chanAddr,
  output logic [LEN_W-1:0]  xferLen,
  output logic              lsbFirst,
  output logic              bipolar,
  output logic [CNT_W-1:0]  fallCnt,
  output logic [CNT_W-1:0]  lastIdx
);
  localparam int HIST_W = ADDR_W - 1;
  localparam logic [RISE_W-1:0] ADDR_LAST = RISE_W'(ADDR_W - 1);
  localparam logic [RISE_W-1:0] LEN_LAST  = RISE_W'(ADDR_W + LEN_W - 1);
  localparam logic [RISE_W-1:0] CMD_LAST  = RISE_W'(CMD_BITS - 1);
  localparam logic [RISE_W-1:0] CMD_END   = RISE_W'(CMD_BITS);

  logic [RISE_W-1:0] riseCnt;
  logic [HIST_W-1:0] hist;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseCnt  <= '0;
      fallCnt  <= '0;
      hist     <= '0;
      chanAddr <= '0;
      xferLen  <= '0;
      lsbFirst <= 1'b0;
      bipolar  <= 1'b0;
    end else if (strb.clr) begin
      riseCnt <= '0;
      fallCnt <= '0;
    end else begin
      if (strb.rise && riseCnt < CMD_END) begin
        riseCnt <= riseCnt + 1'b1;
        hist    <= {hist[HIST_W-2:0], sdi};
        if (riseCnt == ADDR_LAST) chanAddr <= {hist, sdi};
        if (riseCnt == LEN_LAST)  xferLen  <= {hist[0], sdi};
        if (riseCnt == CMD_LAST) begin
          lsbFirst <= hist[0];
          bipolar  <= sdi;
        end
      end
      if (strb.fall) fallCnt <= fallCnt + 1'b1;
    end
  end

  always_comb begin
    case (xferLen)
      2'b01:   lastIdx = CNT_W'(7);
      2'b11:   lastIdx = CNT_W'(15);
      default: lastIdx = CNT_W'(11);
    endcase
  end
endmodule

// File: rtl/adc_seq_control.sv
module adc_seq_control
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csLvl,
  input  logic              csDly,
  input  logic              sclkLvl,
  input  logic              sclkDly,
  input  logic              convDone,
  input  logic [ADDR_W-1:0] chanAddr,
  input  logic [CNT_W-1:0]  fallCnt,
  input  logic [CNT_W-1:0]  lastIdx,
  output ioStrb_t           strb,
  output logic              sampleEn,
  output logic              convStart,
  output logic              eocFlag,
  output logic              powerDown
);
  seqState_t state;
  logic csFall, ioOpen, fourthFall, lastFall, isPd;

  assign csFall     = !csLvl && csDly;
  assign ioOpen     = !csLvl && !csFall && (state == ST_IO);
  assign strb.rise  = ioOpen && sclkLvl && !sclkDly;
  assign strb.fall  = ioOpen && !sclkLvl && sclkDly;
  assign fourthFall = strb.fall && (fallCnt == CNT_W'(SAMPLE_IDX));
  assign lastFall   = strb.fall && (fallCnt == lastIdx);
  assign strb.clr   = csFall || lastFall;
  assign isPd       = (chanAddr == PD_CODE);
  assign eocFlag    = (state != ST_CONV);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IO;
      sampleEn  <= 1'b0;
      convStart <= 1'b0;
      powerDown <= 1'b1;
    end else begin
      convStart <= 1'b0;
      if (csFall) begin
        state    <= ST_IO;
        sampleEn <= 1'b0;
      end else begin
        case (state)
          ST_IO: begin
            if (fourthFall) begin
              if (isPd) powerDown <= 1'b1;
              else      sampleEn  <= 1'b1;
            end
            if (lastFall) begin
              sampleEn <= 1'b0;
              if (!isPd) begin
                powerDown <= 1'b0;
                convStart <= 1'b1;
                state     <= ST_CONV;
              end
            end
          end
          ST_CONV: if (convDone) state <= ST_IO;
          default: state <= ST_IO;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              convDone,
  output logic [ADDR_W-1:0] chanAddr,
  output logic [LEN_W-1:0]  xferLen,
  output logic              lsbFirst,
  output logic              bipolar,
  output logic              sampleEn,
  output logic              convStart,
  output logic              eocFlag,
  output logic              powerDown
);
  logic [1:0] syncLvl, syncDly;
  ioStrb_t strb;
  logic [CNT_W-1:0] fallCnt, lastIdx;

  adc_seq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) i_sync (
    .clk(clk), .rstN(rstN), .asyncIn({csN, sclk}), .lvl(syncLvl), .lvlDly(syncDly)
  );

  adc_seq_control i_ctrl (
    .clk(clk), .rstN(rstN),
    .csLvl(syncLvl[1]), .csDly(syncDly[1]),
    .sclkLvl(syncLvl[0]), .sclkDly(syncDly[0]),
    .convDone(convDone), .chanAddr(chanAddr),
    .fallCnt(fallCnt), .lastIdx(lastIdx), .strb(strb),
    .sampleEn(sampleEn), .convStart(convStart),
    .eocFlag(eocFlag), .powerDown(powerDown)
  );

  adc_seq_datapath i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdi(sdi),
    .chanAddr(chanAddr), .xferLen(xferLen), .lsbFirst(lsbFirst),
    .bipolar(bipolar), .fallCnt(fallCnt), .lastIdx(lastIdx)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic clk,
  input logic rstN,
  input logic sampleEn,
  input logic convStart,
  input logic eocFlag,
  input logic powerDown
);
  // R5
  conv_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);
  // R5
  conv_eoc_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> !eocFlag);
  // R4
  conv_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> !sampleEn);
  // R4
  sample_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |-> eocFlag);
  // R7
  pd_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> !powerDown);
  // R7
  pd_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerDown) |-> !sampleEn);
  // R6
  eoc_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eocFlag) |-> !sampleEn && !convStart);
endmodule

bind adc_seq_ctrl adc_seq_chk i_adc_seq_chk (
  .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .convStart(convStart),
  .eocFlag(eocFlag), .powerDown(powerDown)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN, csN, sclk, sdi, convDone;
  logic [3:0] chanAddr;
  logic [1:0] xferLen;
  logic lsbFirst, bipolar, sampleEn, convStart, eocFlag, powerDown;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [3:0] expQ[$];
  logic [3:0] expAddr;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .convDone(convDone), .chanAddr(chanAddr), .xferLen(xferLen),
    .lsbFirst(lsbFirst), .bipolar(bipolar), .sampleEn(sampleEn),
    .convStart(convStart), .eocFlag(eocFlag), .powerDown(powerDown)
  );

  always #10 clk = ~clk;

  task automatic waitClk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runClocks(logic [7:0] cmd, int from, int upto, logic tail);
    for (int i = from; i < upto; i++) begin
      sdi = (i < 8) ? cmd[7-i] : tail;
      waitClk(HALF);
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
    waitClk(HALF);
  endtask

  task automatic pulseDone();
    convDone = 1'b1;
    waitClk(1);
    convDone = 1'b0;
    waitClk(3);
  endtask

  task automatic csToggle();
    csN = 1'b1;
    waitClk(HALF);
    csN = 1'b0;
    waitClk(HALF);
  endtask

  // scoreboard monitor: every start pulse must match the next expected address (R5)
  always @(negedge clk) begin
    if (rstN === 1'b1 && convStart === 1'b1) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected convStart actual=1 expected=0 (addr %0h)", chanAddr);
      end else begin
        expAddr = expQ.pop_front();
        if (chanAddr !== expAddr) begin
          errors++;
          $display("FAIL R5 start address actual=%0h expected=%0h", chanAddr, expAddr);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; sdi = 1'b0; convDone = 1'b0;
    waitClk(5);
    rstN = 1'b1;
    waitClk(4);
    // R1 reset state
    chk("R1 eocFlag", eocFlag, 1);
    chk("R1 powerDown", powerDown, 1);
    chk("R1 sampleEn", sampleEn, 0);
    chk("R1 command", {chanAddr, xferLen, lsbFirst, bipolar}, 0);
    csN = 1'b0;
    waitClk(HALF);

    // 12-clock cycle, address 5
    runClocks(8'b0101_00_0_0, 0, 4, 1'b0);
    chk("R4 sample opens at 4th fall", sampleEn, 1);
    chk("R2 address after 4 bits", chanAddr, 4'h5);
    runClocks(8'b0101_00_0_0, 4, 11, 1'b0);
    chk("R5 no start before last fall", eocFlag, 1);
    chk("R4 sample still open", sampleEn, 1);
    expQ.push_back(4'h5);
    runClocks(8'b0101_00_0_0, 11, 12, 1'b0);
    chk("R4 sample closes at last fall", sampleEn, 0);
    chk("R5 eoc low at last fall", eocFlag, 0);
    chk("R7 wake clears powerDown", powerDown, 0);
    runClocks(8'h00, 0, 3, 1'b0);
    chk("R10 sclk ignored in conversion", eocFlag, 0);
    pulseDone();
    chk("R6 eoc high after done", eocFlag, 1);

    // 8-clock cycle, address 3, LSB first, bipolar
    runClocks(8'b0011_01_1_1, 0, 7, 1'b0);
    chk("R3 8-clock no start at 7", eocFlag, 1);
    expQ.push_back(4'h3);
    runClocks(8'b0011_01_1_1, 7, 8, 1'b0);
    chk("R3 8-clock start", eocFlag, 0);
    chk("R2 flags", {xferLen, lsbFirst, bipolar}, 4'b01_1_1);
    pulseDone();

    // 16-clock cycle, address B, ones on data after the 8th bit
    runClocks(8'b1011_11_0_0, 0, 15, 1'b1);
    chk("R3 16-clock no start at 15", eocFlag, 1);
    chk("R2 data ignored after 8th bit", {chanAddr, lsbFirst, bipolar}, 6'b1011_0_0);
    expQ.push_back(4'hB);
    runClocks(8'b1011_11_0_0, 15, 16, 1'b1);
    chk("R3 16-clock start", eocFlag, 0);
    pulseDone();

    // length code 10 -> 12 clocks, address A
    runClocks(8'b1010_10_0_0, 0, 11, 1'b0);
    chk("R3 code 10 no start at 11", eocFlag, 1);
    expQ.push_back(4'hA);
    runClocks(8'b1010_10_0_0, 11, 12, 1'b0);
    chk("R3 code 10 start at 12", eocFlag, 0);
    pulseDone();
    pulseDone();
    chk("R6 stray done no effect", {eocFlag, sampleEn}, 2'b10);

    // power-down cycle then wake with address 2
    runClocks(8'b1110_01_0_0, 0, 4, 1'b0);
    chk("R7 powerDown at 4th fall", powerDown, 1);
    chk("R7 no sampling", sampleEn, 0);
    runClocks(8'b1110_01_0_0, 4, 8, 1'b0);
    chk("R7 no conversion", eocFlag, 1);
    chk("R7 stays down", powerDown, 1);
    runClocks(8'b0010_01_0_0, 0, 7, 1'b0);
    chk("R7 down until cycle ends", powerDown, 1);
    expQ.push_back(4'h2);
    runClocks(8'b0010_01_0_0, 7, 8, 1'b0);
    chk("R7 wake at last fall", powerDown, 0);
    chk("R5 wake conversion", eocFlag, 0);
    pulseDone();

    // chip select high: activity ignored
    csN = 1'b1;
    waitClk(HALF);
    runClocks(8'b1001_11_1_1, 0, 16, 1'b1);
    chk("R8 fields unchanged", {chanAddr, xferLen, lsbFirst, bipolar}, 8'b0010_01_0_0);
    chk("R8 no activity", {sampleEn, eocFlag}, 2'b01);
    csN = 1'b0;
    waitClk(HALF);

    // chip select toggle mid-cycle restarts counts
    runClocks(8'b0110_00_0_0, 0, 6, 1'b0);
    csToggle();
    chk("R9 sample closed by cs", sampleEn, 0);
    runClocks(8'b0100_00_0_0, 0, 11, 1'b0);
    chk("R9 counts restarted", eocFlag, 1);
    expQ.push_back(4'h4);
    runClocks(8'b0100_00_0_0, 11, 12, 1'b0);
    chk("R9 start after full cycle", eocFlag, 0);

    // abort a running conversion
    csToggle();
    chk("R9 abort raises eoc", eocFlag, 1);
    pulseDone();
    runClocks(8'b0001_01_0_0, 0, 7, 1'b0);
    expQ.push_back(4'h1);
    runClocks(8'b0001_01_0_0, 7, 8, 1'b0);
    chk("R9 cycle after abort", eocFlag, 0);
    pulseDone();
    chk("R6 eoc high", eocFlag, 1);

    chk("R5 all expected starts seen", expQ.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule